// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked host perform single-word reads and writes on an external asynchronous static RAM that is 16 bits wide and word-addressed by 19 bits. The host raises a request carrying an address, write data, a write flag and a two-bit lane mask. It keeps the request up until a one-cycle acknowledge arrives, and drops it in that acknowledge cycle. Read data comes back together with the acknowledge.

On the memory side the controller produces both chip selects: one is low-active and one is high-active. It also produces a write strobe, an output enable and two low-active lane enables. The bidirectional data bus is split into a drive value, a drive enable and a sampled input, so the tristate buffer sits outside the block. Every memory timing window is given in nanoseconds. Each one becomes a whole number of clock cycles by rounding up against the clock-period parameter, with a floor of one cycle. The controller holds the memory deselected whenever no access is in progress.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever no access is in progress, the memory pins hold the deselected state: sram_ce_n_o=1, sram_ce_o=0, sram_we_n_o=1, sram_oe_n_o=1, sram_be_n_o=2'b11 and sram_dq_oe_o=0. ack_o stays 0 until an access completes.
- R2: Each window length in cycles is max(1, ceil(ns / CLK_NS)). The write strobe length is the larger of the strobe-width and data-setup windows. The read access length is the largest of the read-cycle, address-access and output-enable-access windows.
- R3: A write with a non-zero mask runs in three phases. The first is one select cycle, with the chip selects active and the write strobe high. The second is the strobe phase with sram_we_n_o low for the R2 strobe length. The third is a hold phase with the selects still active and the strobe high, lasting max(1, write-cycle cycles - 1 - strobe length). ack_o then pulses in the first cycle after the hold phase.
- R4: During every cycle of an access, sram_be_n_o[0] is low exactly when mask bit 0 is set, and that lane carries data bits 7:0. sram_be_n_o[1] is low exactly when mask bit 1 is set, and that lane carries bits 15:8.
- R5: sram_dq_oe_o is 1 only while sram_we_n_o is low, and sram_oe_n_o is high then. The drive is released in the same cycle that sram_we_n_o returns high. While it is driven, sram_dq_o equals the write data of the request.
- R6: A read holds the chip selects active, sram_oe_n_o low and sram_we_n_o high for the R2 access length. The data bus is sampled at the end of that window. In the next cycle ack_o is 1 and rdata_o holds the sampled lanes, and any lane whose mask bit is 0 returns 8'h00.
- R7: After a read, sram_oe_n_o stays high and the memory stays deselected for the output-release window (ceil(18/CLK_NS) cycles by default), counting from the acknowledge cycle. A request raised in that window is not started until the window ends and one idle cycle follows.
- R8: A write request with mask 2'b00 is acknowledged in the next cycle. No select, strobe, lane enable or bus drive leaves the deselected state for it, and the stored word is left unchanged.
- R9: ack_o is a single-cycle pulse. A request is taken only when the controller is idle and no acknowledge is showing. sram_addr_o stays constant for as long as the chip selects remain active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Host request, held until acknowledged |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | 8*LANES | Write data |
| req_mask_i | input | LANES | Lane mask, bit n selects bits 8n+7:8n |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8*LANES | Read data, valid with ack_o |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_ce_n_o | output | 1 | Low-active chip select |
| sram_ce_o | output | 1 | High-active chip select |
| sram_we_n_o | output | 1 | Low-active write strobe |
| sram_oe_n_o | output | 1 | Low-active output enable |
| sram_be_n_o | output | LANES | Low-active lane enables |
| sram_dq_o | output | 8*LANES | Data bus drive value |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | 8*LANES | Data bus sampled value |

## Verification
The hardest case to reach is a write request that arrives while the bus is still in the post-read release window. The host cannot see that window; it only sees the acknowledge. To create it, the stimulus raises a new request at the first falling edge after a read acknowledge. The reference model then expects deselected pins for the remaining release cycles, plus one idle cycle, before the select cycle. Partial-lane writes to one address are followed by reads with each mask value, including 2'b00. A model memory returns a non-zero filler value on disabled lanes, so the zero fill of R6 shows at the ports. The zero-mask write is checked by reading back the word it must not have touched.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    // Round a nanosecond window up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) begin
            c = 1;
        end
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_RTURN
    } seq_state_t;

    // Control pins shared by all lanes.
    typedef struct packed {
        logic sel_n;
        logic sel;
        logic we_n;
        logic oe_n;
        logic drive;
        logic lanes_on;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1,
                                        oe_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};

    function automatic strobe_t strobes_for(input seq_state_t s);
        strobe_t r;
        r = STROBE_IDLE;
        case (s)
            ST_WSETUP, ST_WHOLD: begin
                r.sel_n    = 1'b0;
                r.sel      = 1'b1;
                r.lanes_on = 1'b1;
            end
            ST_WPULSE: begin
                r.sel_n    = 1'b0;
                r.sel      = 1'b1;
                r.lanes_on = 1'b1;
                r.we_n     = 1'b0;
                r.drive    = 1'b1;
            end
            ST_RACC: begin
                r.sel_n    = 1'b0;
                r.sel      = 1'b1;
                r.lanes_on = 1'b1;
                r.oe_n     = 1'b0;
            end
            default: r = STROBE_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
`timescale 1ns/1ps
module sram_cyc_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 8,
    parameter int T_WC_NS   = 45,
    parameter int T_PWE_NS  = 35,
    parameter int T_SD_NS   = 25,
    parameter int T_RC_NS   = 45,
    parameter int T_AA_NS   = 45,
    parameter int T_DOE_NS  = 22,
    parameter int T_HZOE_NS = 18
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    req_wr,
    input  logic    req_any_lane,
    output logic    accept,
    output logic    capture,
    output logic    lanes_on_nxt,
    output strobe_t strobes_q,
    output logic    ack_q
);
    localparam int PULSE_CYC = imax(ns_to_cycles(T_PWE_NS, CLK_NS),
                                    ns_to_cycles(T_SD_NS, CLK_NS));
    localparam int WC_CYC    = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int HOLD_CYC  = imax(1, WC_CYC - 1 - PULSE_CYC);
    localparam int ACC_CYC   = imax(imax(ns_to_cycles(T_RC_NS, CLK_NS),
                                         ns_to_cycles(T_AA_NS, CLK_NS)),
                                    ns_to_cycles(T_DOE_NS, CLK_NS));
    localparam int TURN_CYC  = ns_to_cycles(T_HZOE_NS, CLK_NS);
    localparam int MAX_CYC   = imax(imax(PULSE_CYC, HOLD_CYC), imax(ACC_CYC, TURN_CYC));
    localparam int CW        = $clog2(MAX_CYC + 1);

    seq_state_t    st, nxt;
    logic          ld, fin, expired;
    logic [CW-1:0] ld_val;
    strobe_t       strobes_nxt;

    sram_cyc_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    always_comb begin
        nxt     = st;
        ld      = 1'b0;
        ld_val  = '0;
        fin     = 1'b0;
        capture = 1'b0;
        accept  = (st == ST_IDLE) && req && !ack_q;
        case (st)
            ST_IDLE: begin
                if (accept) begin
                    if (req_wr) begin
                        if (!req_any_lane) begin
                            fin = 1'b1;
                        end else begin
                            nxt = ST_WSETUP;
                        end
                    end else begin
                        nxt    = ST_RACC;
                        ld     = 1'b1;
                        ld_val = CW'(ACC_CYC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                nxt    = ST_WPULSE;
                ld     = 1'b1;
                ld_val = CW'(PULSE_CYC - 1);
            end
            ST_WPULSE: begin
                if (expired) begin
                    nxt    = ST_WHOLD;
                    ld     = 1'b1;
                    ld_val = CW'(HOLD_CYC - 1);
                end
            end
            ST_WHOLD: begin
                if (expired) begin
                    nxt = ST_IDLE;
                    fin = 1'b1;
                end
            end
            ST_RACC: begin
                if (expired) begin
                    nxt     = ST_RTURN;
                    ld      = 1'b1;
                    ld_val  = CW'(TURN_CYC - 1);
                    fin     = 1'b1;
                    capture = 1'b1;
                end
            end
            ST_RTURN: begin
                if (expired) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign strobes_nxt  = strobes_for(nxt);
    assign lanes_on_nxt = strobes_nxt.lanes_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            strobes_q <= STROBE_IDLE;
            ack_q     <= 1'b0;
        end else begin
            st        <= nxt;
            strobes_q <= strobes_nxt;
            ack_q     <= fin;
        end
    end
endmodule

// File: rtl/sram_lanes.sv
`timescale 1ns/1ps
module sram_lanes #(
    parameter int LANES = 2,
    localparam int DW   = 8 * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             capture,
    input  logic             lanes_on_nxt,
    input  logic [LANES-1:0] req_mask,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW-1:0]    dq_i,
    output logic [LANES-1:0] be_n,
    output logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic       mask_q, be_n_q, sel_bit;
        logic [7:0] wd_q, rd_q;

        // The incoming mask applies in the accept cycle, the held one after.
        assign sel_bit = accept ? req_mask[g] : mask_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= 1'b0;
                be_n_q <= 1'b1;
                wd_q   <= 8'h00;
                rd_q   <= 8'h00;
            end else begin
                be_n_q <= ~(lanes_on_nxt & sel_bit);
                if (accept) begin
                    mask_q <= req_mask[g];
                    wd_q   <= req_wdata[g*8 +: 8];
                end
                if (capture) begin
                    rd_q <= mask_q ? dq_i[g*8 +: 8] : 8'h00;
                end
            end
        end

        assign be_n[g]         = be_n_q;
        assign wdata[g*8 +: 8] = wd_q;
        assign rdata[g*8 +: 8] = rd_q;
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int LANES     = 2,
    parameter int CLK_NS    = 8,
    parameter int T_WC_NS   = 45,
    parameter int T_PWE_NS  = 35,
    parameter int T_SD_NS   = 25,
    parameter int T_RC_NS   = 45,
    parameter int T_AA_NS   = 45,
    parameter int T_DOE_NS  = 22,
    parameter int T_HZOE_NS = 18,
    localparam int DW       = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DW-1:0]     req_wdata_i,
    input  logic [LANES-1:0]  req_mask_i,
    output logic              ack_o,
    output logic [DW-1:0]     rdata_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_ce_n_o,
    output logic              sram_ce_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o,
    output logic [LANES-1:0]  sram_be_n_o,
    output logic [DW-1:0]     sram_dq_o,
    output logic              sram_dq_oe_o,
    input  logic [DW-1:0]     sram_dq_i
);
    logic              accept, capture, lanes_on_nxt;
    strobe_t           strobes;
    logic [ADDR_W-1:0] addr_q;

    sram_seq #(
        .CLK_NS    (CLK_NS),
        .T_WC_NS   (T_WC_NS),
        .T_PWE_NS  (T_PWE_NS),
        .T_SD_NS   (T_SD_NS),
        .T_RC_NS   (T_RC_NS),
        .T_AA_NS   (T_AA_NS),
        .T_DOE_NS  (T_DOE_NS),
        .T_HZOE_NS (T_HZOE_NS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req          (req_i),
        .req_wr       (req_wr_i),
        .req_any_lane (|req_mask_i),
        .accept       (accept),
        .capture      (capture),
        .lanes_on_nxt (lanes_on_nxt),
        .strobes_q    (strobes),
        .ack_q        (ack_o)
    );

    sram_lanes #(.LANES(LANES)) u_lanes (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .capture      (capture),
        .lanes_on_nxt (lanes_on_nxt),
        .req_mask     (req_mask_i),
        .req_wdata    (req_wdata_i),
        .dq_i         (sram_dq_i),
        .be_n         (sram_be_n_o),
        .wdata        (sram_dq_o),
        .rdata        (rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr_i;
        end
    end

    assign sram_addr_o  = addr_q;
    assign sram_ce_n_o  = strobes.sel_n;
    assign sram_ce_o    = strobes.sel;
    assign sram_we_n_o  = strobes.we_n;
    assign sram_oe_n_o  = strobes.oe_n;
    assign sram_dq_oe_o = strobes.drive;
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int CLK_NS    = 8,
    parameter int T_PWE_NS  = 35,
    parameter int T_SD_NS   = 25,
    parameter int T_HZOE_NS = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_o,
    input logic [ADDR_W-1:0] sram_addr_o,
    input logic              sram_ce_n_o,
    input logic              sram_ce_o,
    input logic              sram_we_n_o,
    input logic              sram_oe_n_o,
    input logic              sram_dq_oe_o
);
    localparam int PULSE_MIN = imax(ns_to_cycles(T_PWE_NS, CLK_NS), ns_to_cycles(T_SD_NS, CLK_NS));
    localparam int TURN_MIN  = ns_to_cycles(T_HZOE_NS, CLK_NS);

    logic [7:0] we_low_cnt, oe_high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt  <= 8'd0;
            oe_high_cnt <= 8'hFF;
        end else begin
            we_low_cnt  <= !sram_we_n_o ? ((we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1) : 8'd0;
            oe_high_cnt <= !sram_oe_n_o ? 8'd0 : ((oe_high_cnt == 8'hFF) ? oe_high_cnt : oe_high_cnt + 8'd1);
        end
    end

    // R1: a write strobe only ever appears with both selects active
    a_r1_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n_o |-> (!sram_ce_n_o && sram_ce_o));

    // R3: the strobe lasts at least the required cycle count
    a_r3_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n_o) |-> (int'(we_low_cnt) >= PULSE_MIN));

    // R5: bus driven only inside a write strobe with output enable off
    a_r5_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe_o |-> (!sram_we_n_o && sram_oe_n_o));

    // R5: drive released together with the strobe
    a_r5_release_with_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n_o) |-> !sram_dq_oe_o);

    // R6: output enable never overlaps a write strobe
    a_r6_no_oe_during_write: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n_o |-> sram_we_n_o);

    // R7: no bus drive before the memory has released it
    a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe_o |-> (int'(oe_high_cnt) >= TURN_MIN));

    // R9: acknowledge is a single pulse
    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    // R9: address holds while selected
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n_o && $past(!sram_ce_n_o)) |-> $stable(sram_addr_o));
endmodule

bind sram_async_ctrl sram_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .CLK_NS    (CLK_NS),
    .T_PWE_NS  (T_PWE_NS),
    .T_SD_NS   (T_SD_NS),
    .T_HZOE_NS (T_HZOE_NS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ack_o        (ack_o),
    .sram_addr_o  (sram_addr_o),
    .sram_ce_n_o  (sram_ce_n_o),
    .sram_ce_o    (sram_ce_o),
    .sram_we_n_o  (sram_we_n_o),
    .sram_oe_n_o  (sram_oe_n_o),
    .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0, req_wr_i = 1'b0;
    logic [18:0] req_addr_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic [1:0]  req_mask_i = '0;
    logic        ack_o;
    logic [15:0] rdata_o;
    logic [18:0] sram_addr_o;
    logic        sram_ce_n_o, sram_ce_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o;
    logic [1:0]  sram_be_n_o;
    logic [15:0] sram_dq_o;
    logic [15:0] sram_dq_i = 16'hA5A5;

    int total = 0;
    int bad   = 0;
    int wait_extra = 0;

    logic [18:0] cur_addr;
    logic [15:0] cur_data;
    logic [1:0]  cur_mask;

    logic [15:0] cells   [int unsigned];
    logic [15:0] ref_mem [int unsigned];

    always #4 clk = ~clk;

    sram_async_ctrl u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .req_wr_i(req_wr_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_mask_i(req_mask_i),
        .ack_o(ack_o), .rdata_o(rdata_o), .sram_addr_o(sram_addr_o),
        .sram_ce_n_o(sram_ce_n_o), .sram_ce_o(sram_ce_o), .sram_we_n_o(sram_we_n_o),
        .sram_oe_n_o(sram_oe_n_o), .sram_be_n_o(sram_be_n_o), .sram_dq_o(sram_dq_o),
        .sram_dq_oe_o(sram_dq_oe_o), .sram_dq_i(sram_dq_i)
    );

    // Window lengths from the requirements (R2), 8 ns period.
    function automatic int cyc(input int ns);
        int c;
        c = (ns + 7) / 8;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    int e_pulse, e_hold, e_acc, e_turn;

    // Behavioural memory on the pin side; drives filler on disabled lanes.
    always @(posedge clk) begin
        logic [15:0] w;
        logic [15:0] rd;
        logic        rd_en;
        if (!sram_we_n_o && !sram_ce_n_o && sram_ce_o && sram_dq_oe_o) begin
            w = cells.exists(int'(sram_addr_o)) ? cells[int'(sram_addr_o)] : 16'h0000;
            if (!sram_be_n_o[0]) w[7:0]  = sram_dq_o[7:0];
            if (!sram_be_n_o[1]) w[15:8] = sram_dq_o[15:8];
            cells[int'(sram_addr_o)] = w;
        end
        rd = cells.exists(int'(sram_addr_o)) ? cells[int'(sram_addr_o)] : 16'h0000;
        rd_en = !sram_ce_n_o && sram_ce_o && !sram_oe_n_o && sram_we_n_o;
        sram_dq_i[7:0]  <= (rd_en && !sram_be_n_o[0]) ? rd[7:0]  : 8'hA5;
        sram_dq_i[15:8] <= (rd_en && !sram_be_n_o[1]) ? rd[15:8] : 8'hA5;
    end

    // ph: 0 deselected, 1 selected without strobe, 2 write strobe, 3 read strobe
    task automatic chk(input int ph, input logic exp_ack, input string tag);
        logic [7:0] exp_v, act_v;
        logic [1:0] be;
        be = (ph == 0) ? 2'b11 : ~cur_mask;
        case (ph)
            1:       exp_v = {1'b0, 1'b1, 1'b1, 1'b1, be, 1'b0, exp_ack};
            2:       exp_v = {1'b0, 1'b1, 1'b0, 1'b1, be, 1'b1, exp_ack};
            3:       exp_v = {1'b0, 1'b1, 1'b1, 1'b0, be, 1'b0, exp_ack};
            default: exp_v = {1'b1, 1'b0, 1'b1, 1'b1, be, 1'b0, exp_ack};
        endcase
        act_v = {sram_ce_n_o, sram_ce_o, sram_we_n_o, sram_oe_n_o, sram_be_n_o, sram_dq_oe_o, ack_o};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s pins {ce_n,ce,we_n,oe_n,be_n,dq_oe,ack} act=%b exp=%b", tag, act_v, exp_v);
        end
        if (ph != 0) begin
            total++;
            if (sram_addr_o !== cur_addr) begin
                bad++;
                $display("FAIL R9 address act=%h exp=%h", sram_addr_o, cur_addr);
            end
        end
        if (ph == 2) begin
            total++;
            if (sram_dq_o !== cur_data) begin
                bad++;
                $display("FAIL R5 drive data act=%h exp=%h", sram_dq_o, cur_data);
            end
        end
    endtask

    task automatic xfer(input logic wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] m, input string tag);
        logic [15:0] old, expd;
        @(negedge clk);
        chk(0, 1'b0, "R1 R9");
        cur_addr = a; cur_data = d; cur_mask = m;
        req_i = 1'b1; req_wr_i = wr; req_addr_i = a; req_wdata_i = d; req_mask_i = m;
        for (int i = 0; i < wait_extra; i++) begin
            @(negedge clk); chk(0, 1'b0, "R7");
        end
        if (wr) begin
            if (m == 2'b00) begin
                @(negedge clk); chk(0, 1'b1, "R8");
            end else begin
                @(negedge clk); chk(1, 1'b0, tag);
                for (int i = 0; i < e_pulse; i++) begin
                    @(negedge clk); chk(2, 1'b0, "R2 R3 R4 R5");
                end
                for (int i = 0; i < e_hold; i++) begin
                    @(negedge clk); chk(1, 1'b0, "R3 R5");
                end
                @(negedge clk); chk(0, 1'b1, "R3 R9");
                old = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
                if (m[0]) old[7:0]  = d[7:0];
                if (m[1]) old[15:8] = d[15:8];
                ref_mem[int'(a)] = old;
            end
            wait_extra = 0;
        end else begin
            for (int i = 0; i < e_acc; i++) begin
                @(negedge clk); chk(3, 1'b0, "R2 R4 R6");
            end
            @(negedge clk); chk(0, 1'b1, "R6 R7");
            old  = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
            expd = {m[1] ? old[15:8] : 8'h00, m[0] ? old[7:0] : 8'h00};
            total++;
            if (rdata_o !== expd) begin
                bad++;
                $display("FAIL %s read data act=%h exp=%h", tag, rdata_o, expd);
            end
            wait_extra = e_turn - 1;
        end
        req_i = 1'b0;
    endtask

    initial begin
        e_pulse = mx(cyc(35), cyc(25));
        e_hold  = mx(1, cyc(45) - 1 - e_pulse);
        e_acc   = mx(mx(cyc(45), cyc(45)), cyc(22));
        e_turn  = cyc(18);
        cur_addr = '0; cur_data = '0; cur_mask = '0;
        repeat (2) @(negedge clk);
        chk(0, 1'b0, "R1 reset");
        @(negedge clk);
        chk(0, 1'b0, "R1 reset");
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); chk(0, 1'b0, "R1 idle");
        end

        xfer(1'b1, 19'h00010, 16'hBEEF, 2'b11, "R3 full write");
        xfer(1'b0, 19'h00010, 16'h0000, 2'b11, "R6 full read");
        xfer(1'b1, 19'h7FFFF, 16'h1234, 2'b01, "R4 low lane write");
        xfer(1'b1, 19'h7FFFF, 16'hAB00, 2'b10, "R4 high lane write");
        xfer(1'b0, 19'h7FFFF, 16'h0000, 2'b11, "R4 merged read");
        xfer(1'b0, 19'h7FFFF, 16'h0000, 2'b01, "R6 low lane read");
        xfer(1'b0, 19'h7FFFF, 16'h0000, 2'b10, "R6 high lane read");
        xfer(1'b0, 19'h7FFFF, 16'h0000, 2'b00, "R6 no lane read");
        xfer(1'b1, 19'h00010, 16'h0000, 2'b00, "R8 empty mask write");
        xfer(1'b0, 19'h00010, 16'h0000, 2'b11, "R8 word untouched");
        xfer(1'b1, 19'h2AAAA, 16'h5AC3, 2'b11, "R7 write after read");
        xfer(1'b0, 19'h2AAAA, 16'h0000, 2'b11, "R6 readback");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); chk(0, 1'b0, "R1 final idle");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule